// File: doc/BRIEF.md
# Anti-Diagonal Wavefront Sequence Aligner

This block scores the alignment of two short symbol strings with a linear array of cell processors. Processor *i* holds symbol *i* of the first string, which is the row string. The second string, which is the column string, enters one symbol per accepted beat and moves one processor further along the array on each clock. With contiguous streaming, all the cells that the array evaluates in one clock lie on a single anti-diagonal of the scoring table. Each cell needs only its diagonal, upper and left neighbours, so those cells are independent of one another. An m-by-n table therefore takes m + n − 1 evaluation steps.

A mode value, latched at start, selects one of three scorings: global, local or semi-global. The mode sets the boundary values of the table, whether cell values are clamped at zero, and which cells may supply the result. The match reward, the mismatch penalty and the gap penalty are unsigned inputs, also latched at start. Only the best score and the position of the cell that holds it are reported, together with a completion flag.

To use the block, write the row string with the load port, pulse start with the mode, the row length and the scoring values, then stream the column string with a valid bit and mark its final symbol.

Top module: `wavefront_aligner`

## Requirements
- R1: After reset, `done` is 0.
- R2: In global mode (mode 0), boundary cell k of the top row and of the left column holds −k·gap. The result is the cell at row a_len, column n, and it is reported at that position.
- R3: In local mode (mode 1), every cell value is clamped at zero from below. The result is the maximum over all cells, so the reported score is never negative.
- R4: In semi-global mode (mode 2), the boundary cells are 0. The result is the maximum over the cells of row a_len and column n.
- R5: A cell takes the largest of three values: diagonal plus match reward when the row and column symbols are equal, diagonal minus mismatch penalty when they differ, and the larger of upper and left minus the gap penalty.
- R6: With contiguous streaming, equal candidate scores resolve to the one on the earlier anti-diagonal. Within one anti-diagonal, the smaller row wins. For example, a local run with no matching symbol reports score 0 at row 1, column 1.
- R7: `done` rises exactly a_len clock edges after the edge that accepts the symbol marked last. It then holds until the next start.
- R8: The edge that samples `start` clears `done`.
- R9: Any row length from 1 to NPE and any column length from 1 upward give the correct result, including strings of unequal length and strings of length 1.
- R10: Beats with `b_valid` low are ignored. Idle gaps inside the column stream leave the reported score unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_we | input | 1 | Write one row-string symbol |
| a_idx | input | IW | Position of the row symbol being written (0-based) |
| a_chr | input | CHW | Row symbol value |
| start | input | 1 | Begin a run; latches mode, a_len and the scoring values |
| mode | input | 2 | 0 global, 1 local, 2 semi-global |
| a_len | input | RW | Row-string length, 1..NPE |
| match_sc | input | PW | Reward for equal symbols |
| mis_pen | input | PW | Penalty for unequal symbols |
| gap_pen | input | PW | Penalty per gap |
| b_valid | input | 1 | Column symbol present this beat |
| b_chr | input | CHW | Column symbol value |
| b_last | input | 1 | Marks the final column symbol |
| done | output | 1 | Result valid |
| best_score | output | SW | Signed best score |
| best_row | output | RW | Row of the best cell (1-based) |
| best_col | output | JW | Column of the best cell (1-based) |

## Verification
A column symbol accepted at one edge reaches processor i after i + 1 edges. The final cell is therefore registered, and `done` raised, a_len edges after the edge that accepted the last symbol. The bench stops driving at that edge and counts falling edges until `done` is seen, which gives the latency exactly. It reads the score and position on the same falling edge. The start-clears-done check samples on the falling edge right after the start edge. Every result is compared with a dynamic-programming model in the bench that scans the anti-diagonals in order.

// File: rtl/wavefront_aligner.sv
`timescale 1ns/1ps
module wavefront_aligner #(
  parameter int NPE = 8,
  parameter int CHW = 2,
  parameter int SW  = 12,
  parameter int PW  = 4,
  parameter int JW  = 6,
  localparam int RW = $clog2(NPE + 1),
  localparam int IW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_we,
  input  logic [IW-1:0]        a_idx,
  input  logic [CHW-1:0]       a_chr,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [RW-1:0]        a_len,
  input  logic [PW-1:0]        match_sc,
  input  logic [PW-1:0]        mis_pen,
  input  logic [PW-1:0]        gap_pen,
  input  logic                 b_valid,
  input  logic [CHW-1:0]       b_chr,
  input  logic                 b_last,
  output logic                 done,
  output logic signed [SW-1:0] best_score,
  output logic [RW-1:0]        best_row,
  output logic [JW-1:0]        best_col
);
  localparam logic [1:0] M_GLB = 2'd0, M_LOC = 2'd1, M_SEMI = 2'd2;

  logic [CHW-1:0] a_q [NPE];
  logic [1:0]     mode_q;
  logic [RW-1:0]  alen_q;
  logic [PW-1:0]  ms_q, mx_q, gp_q;
  logic [JW-1:0]  col_cnt;
  logic           have, have_n, fin;

  logic                 v [NPE];
  logic                 l [NPE];
  logic [CHW-1:0]       c [NPE];
  logic [JW-1:0]        j [NPE];
  logic signed [SW-1:0] h [NPE], d [NPE], hn [NPE], upv [NPE];
  logic signed [SW-1:0] bs_n;
  logic [RW-1:0]        br_n;
  logic [JW-1:0]        bc_n;

  wire signed [SW-1:0] ms_s = {{(SW-PW){1'b0}}, ms_q};
  wire signed [SW-1:0] mx_s = {{(SW-PW){1'b0}}, mx_q};
  wire signed [SW-1:0] gp_s = {{(SW-PW){1'b0}}, gp_q};
  wire                 glb  = (mode_q == M_GLB);

  function automatic logic signed [SW-1:0] bnd(input int k, input logic g, input logic [PW-1:0] p);
    return g ? SW'(-(k * int'(p))) : '0;
  endfunction

  always_ff @(posedge clk)
    if (a_we) a_q[a_idx] <= a_chr;

  always_comb begin
    for (int i = 0; i < NPE; i++) begin
      logic signed [SW-1:0] lf, dg, sc, t;
      upv[i] = (i == 0) ? bnd(int'(j[i]), glb, gp_q) : h[(i == 0) ? 0 : i - 1];
      lf = (j[i] == JW'(1)) ? bnd(i + 1, glb, gp_q) : h[i];
      dg = (j[i] == JW'(1)) ? bnd(i, glb, gp_q) : d[i];
      sc = dg + ((a_q[i] == c[i]) ? ms_s : -mx_s);
      t  = ((upv[i] > lf) ? upv[i] : lf) - gp_s;
      hn[i] = (sc > t) ? sc : t;
      if (mode_q == M_LOC && hn[i][SW-1]) hn[i] = '0;
    end
  end

  always_comb begin
    bs_n = best_score; br_n = best_row; bc_n = best_col; have_n = have; fin = 1'b0;
    for (int i = 0; i < NPE; i++) begin
      logic lr, el;
      lr = (i == int'(alen_q) - 1);
      case (mode_q)
        M_LOC:   el = 1'b1;
        M_SEMI:  el = lr || l[i];
        default: el = lr && l[i];
      endcase
      if (v[i] && i < int'(alen_q) && el && (!have_n || hn[i] > bs_n)) begin
        bs_n = hn[i]; br_n = RW'(i + 1); bc_n = j[i]; have_n = 1'b1;
      end
      if (v[i] && l[i] && lr) fin = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; have <= 1'b0; best_score <= '0; best_row <= '0; best_col <= '0;
      col_cnt <= '0; mode_q <= M_GLB; alen_q <= RW'(1); ms_q <= '0; mx_q <= '0; gp_q <= '0;
      for (int i = 0; i < NPE; i++) begin
        v[i] <= 1'b0; l[i] <= 1'b0; c[i] <= '0; j[i] <= '0; h[i] <= '0; d[i] <= '0;
      end
    end else if (start) begin
      mode_q <= mode; alen_q <= a_len; ms_q <= match_sc; mx_q <= mis_pen; gp_q <= gap_pen;
      done <= 1'b0; have <= 1'b0; col_cnt <= '0;
      for (int i = 0; i < NPE; i++) v[i] <= 1'b0;
    end else begin
      v[0] <= b_valid; c[0] <= b_chr; l[0] <= b_last; j[0] <= col_cnt + JW'(1);
      if (b_valid) col_cnt <= col_cnt + JW'(1);
      for (int i = 1; i < NPE; i++) begin
        v[i] <= v[i-1]; c[i] <= c[i-1]; l[i] <= l[i-1]; j[i] <= j[i-1];
      end
      for (int i = 0; i < NPE; i++)
        if (v[i]) begin h[i] <= hn[i]; d[i] <= upv[i]; end
      best_score <= bs_n; best_row <= br_n; best_col <= bc_n; have <= have_n;
      if (fin) done <= 1'b1;
    end
  end
endmodule

// File: rtl/wavefront_aligner_chk.sv
`timescale 1ns/1ps
module wavefront_aligner_chk #(
  parameter int SW = 12,
  parameter int RW = 4,
  parameter int JW = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 done,
  input logic [1:0]           mode_q,
  input logic [RW-1:0]        alen_q,
  input logic [JW-1:0]        col_cnt,
  input logic signed [SW-1:0] best_score,
  input logic [RW-1:0]        best_row,
  input logic [JW-1:0]        best_col
);
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  p_local_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'd1 |-> !best_score[SW-1]);
  p_global_corner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'd0 |-> best_row == alen_q && best_col == col_cnt);
  p_semi_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q == 2'd2 |-> best_row == alen_q || best_col == col_cnt);
  p_row_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> best_row >= RW'(1) && best_row <= alen_q && best_col >= JW'(1));
endmodule

bind wavefront_aligner wavefront_aligner_chk #(.SW(SW), .RW(RW), .JW(JW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mode_q(mode_q),
  .alen_q(alen_q), .col_cnt(col_cnt), .best_score(best_score),
  .best_row(best_row), .best_col(best_col));

// File: tb/wavefront_aligner_tb.sv
`timescale 1ns/1ps
module wavefront_aligner_tb;
  logic clk = 0, rst_n = 0;
  logic a_we = 0, start = 0, b_valid = 0, b_last = 0;
  logic [2:0] a_idx = 0;
  logic [1:0] a_chr = 0, b_chr = 0, mode = 0;
  logic [3:0] a_len = 1, match_sc = 1, mis_pen = 1, gap_pen = 1;
  logic done;
  logic signed [11:0] best_score;
  logic [3:0] best_row;
  logic [5:0] best_col;
  int checks = 0, errors = 0;
  int A [8];
  int B [32];
  int H [0:8][0:32];
  int e_s, e_r, e_c;

  always #5 clk = ~clk;

  wavefront_aligner u_dut (.clk(clk), .rst_n(rst_n), .a_we(a_we), .a_idx(a_idx), .a_chr(a_chr),
    .start(start), .mode(mode), .a_len(a_len), .match_sc(match_sc), .mis_pen(mis_pen),
    .gap_pen(gap_pen), .b_valid(b_valid), .b_chr(b_chr), .b_last(b_last), .done(done),
    .best_score(best_score), .best_row(best_row), .best_col(best_col));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(int md, int m, int n, int ms, int xs, int gs);
    bit have = 0;
    for (int k = 0; k <= 32; k++) begin
      H[0][k] = (md == 0) ? -k * gs : 0;
      if (k <= 8) H[k][0] = (md == 0) ? -k * gs : 0;
    end
    for (int i = 1; i <= m; i++)
      for (int k = 1; k <= n; k++) begin
        int s, t;
        s = H[i-1][k-1] + ((A[i-1] == B[k-1]) ? ms : -xs);
        t = ((H[i-1][k] > H[i][k-1]) ? H[i-1][k] : H[i][k-1]) - gs;
        H[i][k] = (s > t) ? s : t;
        if (md == 1 && H[i][k] < 0) H[i][k] = 0;
      end
    for (int dg = 2; dg <= m + n; dg++)
      for (int i = 1; i <= m; i++) begin
        int k = dg - i;
        bit el;
        if (k < 1 || k > n) continue;
        el = (md == 1) || (md == 2 && (i == m || k == n)) || (md == 0 && i == m && k == n);
        if (el && (!have || H[i][k] > e_s)) begin
          have = 1; e_s = H[i][k]; e_r = i; e_c = k;
        end
      end
  endtask

  task automatic run(string tag, int md, int m, int n, int ms, int xs, int gs, bit gaps, bit pos);
    int cnt = 0;
    for (int i = 0; i < m; i++) begin
      @(negedge clk); a_we = 1; a_idx = 3'(i); a_chr = 2'(A[i]);
    end
    @(negedge clk); a_we = 0; start = 1; mode = 2'(md); a_len = 4'(m);
    match_sc = 4'(ms); mis_pen = 4'(xs); gap_pen = 4'(gs);
    @(negedge clk); start = 0;
    chk({tag, " R8 start clears done"}, int'(done), 0);
    for (int k = 0; k < n; k++) begin
      b_valid = 1; b_chr = 2'(B[k]); b_last = (k == n - 1);
      @(negedge clk);
      if (gaps && k != n - 1) begin b_valid = 0; repeat (2) @(negedge clk); end
    end
    b_valid = 0; b_last = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    model(md, m, n, ms, xs, gs);
    if (!gaps) chk({tag, " R7 done latency"}, cnt, m);
    chk({tag, " R5 score"}, int'(best_score), e_s);
    if (pos) begin
      chk({tag, " R6 row"}, int'(best_row), e_r);
      chk({tag, " R6 col"}, int'(best_col), e_c);
    end
    repeat (2) @(negedge clk);
    chk({tag, " R7 done holds"}, int'(done), 1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ml [8] = '{1, 1, 5, 8, 3, 8, 6, 2};
    int nl [8] = '{1, 5, 1, 8, 7, 12, 4, 2};
    repeat (3) @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);
    for (int md = 0; md < 3; md++)
      for (int rep = 0; rep < 3; rep++)
        for (int t = 0; t < 8; t++) begin
          int sym = (rep == 0) ? 2 : 4;
          for (int i = 0; i < 8; i++) A[i] = $urandom % sym;
          for (int k = 0; k < 32; k++) B[k] = $urandom % sym;
          if (md == 0) run("R2 R9 global", md, ml[t], nl[t], 1 + t % 2, 1, 1 + t % 2, 0, 1);
          else if (md == 1) run("R3 R9 local", md, ml[t], nl[t], 1 + t % 2, 1, 1 + t % 2, 0, 1);
          else run("R4 R9 semi", md, ml[t], nl[t], 1 + t % 2, 1, 1 + t % 2, 0, 1);
        end
    for (int i = 0; i < 8; i++) A[i] = 0;
    for (int k = 0; k < 32; k++) B[k] = 1;
    run("R6 R3 local no match", 1, 6, 5, 1, 1, 1, 0, 1);
    chk("R6 tie origin row", int'(best_row), 1);
    chk("R6 tie origin col", int'(best_col), 1);
    run("R2 global no match", 0, 4, 6, 2, 3, 2, 0, 1);
    for (int md = 0; md < 3; md++) begin
      for (int i = 0; i < 8; i++) A[i] = $urandom % 4;
      for (int k = 0; k < 32; k++) B[k] = $urandom % 4;
      run("R10 gaps", md, 7, 9, 2, 1, 1, 1, md == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule